// File: doc/BRIEF.md
# Character Buffer Write Controller

This block sits between a microprocessor-style write bus and a small character memory. It holds eight locations, each six bits wide. The block qualifies a write strobe with a set of chip selects. It captures the control inputs at the start of the strobe and the data word at its end. The word is then stored at a location chosen by one of two entry modes. In random mode the location comes from a 3-bit field on the shared control lines. In sequential mode an internal counter supplies the location. In that mode the same lines act as an enable input and a clear input, and a full flag is produced so that several controllers can be chained.

All bus inputs are synchronized into one system clock domain. Strobe edges are detected there as single-cycle pulses. A combinational read port lets the display scan logic fetch any entry. A busy output tells the scan logic when an accepted write is in progress. A standby input silences the full-flag pin without disturbing the stored characters.

Top module: `chrbuf_wr_ctrl`

## Requirements
- R1: A write takes place only when `wr_n` is low and every bit of `sel` is high. A strobe with any select low changes no entry and no counter state.
- R2: `mode` is captured at the start of the effective strobe, where 1 selects sequential entry and 0 selects random entry. The captured mode governs the clear input, the full flag and the location source until the next strobe start.
- R3: In random mode the location is `ctl[2:0]` as captured at the strobe start. Later changes on `ctl` during the strobe do not alter the location written.
- R4: The data word `din` is captured at the end of the strobe and stored at the selected location, where `rd_data` shows it for `rd_addr`.
- R5: In sequential mode the enable is `ctl[0]`, captured at the strobe start. A write is made only if that enable was 1 and the full flag was 0; otherwise no entry and no counter changes.
- R6: In sequential mode each accepted write goes to the counter location, starting at 0 and rising by one per write. The full flag goes high after eight accepted writes.
- R7: While sequential mode is latched, `ctl[1]` low resets the counter to 0, sets every entry to the blank code 6'b100000 and drops the full flag. In random mode `ctl[1]` low has no effect.
- R8: `full_oe` rises at the end of the first strobe that latched sequential mode. It falls at the start of a strobe that latches random mode. `full_o` is low whenever `full_oe` is low.
- R9: `wr_busy` is high during an accepted strobe and low otherwise. In random mode every strobe is accepted; in sequential mode only strobes that meet R5 are accepted.
- R10: `standby` high forces `full_o` low and leaves the memory contents unchanged.
- R11: After reset every entry holds 6'b100000, the counter is 0, mode is random, and `full_o`, `full_oe` and `wr_busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_n | input | 1 | Write strobe from the bus, active low |
| sel | input | NUM_SEL | Chip selects, all must be high to enable the strobe |
| mode | input | 1 | Entry mode request: 1 sequential, 0 random |
| ctl | input | 3 | Random: location; sequential: bit0 enable, bit1 clear (active low) |
| din | input | 6 | Character code |
| standby | input | 1 | Forces the full-flag output low |
| rd_addr | input | 3 | Scan read location |
| rd_data | output | 6 | Character code stored at `rd_addr` |
| full_o | output | 1 | Sequential full flag for chaining |
| full_oe | output | 1 | Drive enable for the shared full-flag pin |
| wr_busy | output | 1 | Accepted write in progress |

## Verification
The bench builds the block with its defaults: eight locations, six-bit codes, two chip selects and two synchronizer stages. Eight locations make the counter wrap to full within a few dozen strobes. The full flag, the ignored ninth write and the clear from a full state are all reached directly. Random traffic then mixes mode switches, partial selects, mid-strobe address and enable changes, and clears. This exercises the ordering between start capture, end capture and the latched mode.

// File: rtl/chrbuf_pkg.sv
// Package: shared widths and the blank character code for the buffer controller.
// Assumes codes are at least two bits wide.
package chrbuf_pkg;
    parameter int unsigned CODE_W  = 6;
    parameter int unsigned ENTRIES = 8;

    // Blank code: MSB set, remaining bits clear.
    function automatic logic [CODE_W-1:0] blank_code();
        logic [CODE_W-1:0] b;
        b = '0;
        b[CODE_W-1] = 1'b1;
        return b;
    endfunction
endpackage

// File: rtl/chrbuf_sync.sv
// Module: multi-stage synchronizer for a bus of asynchronous inputs.
// Assumes all bits are sampled together, so skew between bits is not resolved.
module chrbuf_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Shift the input one stage further into the clock domain.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    chain[s] <= RST_VAL;
                else if (s == 0)
                    chain[s] <= d;
                else
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/chrbuf_strobe.sv
// Module: qualifies the write strobe with all chip selects and emits start/end pulses.
// Assumes synchronized inputs; the start is the last enabling edge, the end the first disabling one.
module chrbuf_strobe #(
    parameter int unsigned NUM_SEL = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_n_s,
    input  logic [NUM_SEL-1:0] sel_s,
    output logic               act,
    output logic               start_p,
    output logic               end_p
);
    logic gate_now;

    assign gate_now = ~wr_n_s & (&sel_s);

    // Register the gated strobe to find its edges.
    always_ff @(posedge clk) begin
        if (!rst_n) act <= 1'b0;
        else        act <= gate_now;
    end

    assign start_p = gate_now & ~act;
    assign end_p   = ~gate_now & act;
endmodule

// File: rtl/chrbuf_seq_ctr.sv
// Module: sequential location counter with overflow (full) flag.
// Assumes the increment is never requested while full.
module chrbuf_seq_ctr #(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_i,
    input  logic          clr_i,
    output logic [AW-1:0] loc_o,
    output logic          full_o
);
    logic [CW-1:0] cnt_q;

    // Count accepted sequential writes; clear wins over increment.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) cnt_q <= '0;
        else if (inc_i)      cnt_q <= cnt_q + 1'b1;
    end

    assign loc_o  = cnt_q[AW-1:0];
    assign full_o = (cnt_q == CW'(DEPTH));

    // R6
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_i && !clr_i) |=> $stable(cnt_q));
    // R6
    full_only_after_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_o) |-> $past(inc_i));
endmodule

// File: rtl/chrbuf_mem.sv
// Module: character storage with one write port, a bulk clear to blank and a read port.
// Assumes clear has priority over a write in the same cycle.
module chrbuf_mem #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned W     = 6,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] wa_i,
    input  logic [W-1:0]  wd_i,
    input  logic          clr_i,
    input  logic [AW-1:0] ra_i,
    output logic [W-1:0]  rd_o
);
    localparam logic [W-1:0] BLANK = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] mem_q [DEPTH];

    genvar i;
    generate
        for (i = 0; i < DEPTH; i++) begin : g_ent
            // Hold one character; blank on reset or clear, load on a matching write.
            always_ff @(posedge clk) begin
                if (!rst_n || clr_i)
                    mem_q[i] <= BLANK;
                else if (we_i && wa_i == AW'(i))
                    mem_q[i] <= wd_i;
            end

            // R7
            blank_after_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
                clr_i |=> (mem_q[i] == BLANK));
        end
    endgenerate

    assign rd_o = mem_q[ra_i];
endmodule

// File: rtl/chrbuf_wr_ctrl.sv
// Module: top of the character buffer write controller.
// Synchronizes bus inputs, captures mode/location/enable at strobe start and data at strobe end,
// and drives the memory, counter, full flag and busy status.
// Assumes ctl[1] is held high around a switch into or out of sequential mode.
module chrbuf_wr_ctrl #(
    parameter int unsigned DEPTH   = chrbuf_pkg::ENTRIES,
    parameter int unsigned CODE_W  = chrbuf_pkg::CODE_W,
    parameter int unsigned NUM_SEL = 2,
    parameter int unsigned STAGES  = 2,
    localparam int unsigned AW     = $clog2(DEPTH),
    localparam int unsigned BUS_W  = 2 + NUM_SEL + AW + CODE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_n,
    input  logic [NUM_SEL-1:0] sel,
    input  logic               mode,
    input  logic [AW-1:0]      ctl,
    input  logic [CODE_W-1:0]  din,
    input  logic               standby,
    input  logic [AW-1:0]      rd_addr,
    output logic [CODE_W-1:0]  rd_data,
    output logic               full_o,
    output logic               full_oe,
    output logic               wr_busy
);
    localparam logic [BUS_W-1:0] BUS_RST = {1'b1, {(BUS_W-1){1'b0}}};

    logic               wr_n_s, mode_s;
    logic [NUM_SEL-1:0] sel_s;
    logic [AW-1:0]      ctl_s;
    logic [CODE_W-1:0]  din_s;
    logic               strb_act, start_p, end_p;
    logic               mode_q, busy_q, oe_q;
    logic [AW-1:0]      addr_q;
    logic [AW-1:0]      seq_loc;
    logic               seq_full, clr, mem_we, seq_inc;
    logic [AW-1:0]      wr_loc;

    chrbuf_sync #(.W(BUS_W), .STAGES(STAGES), .RST_VAL(BUS_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({wr_n, mode, sel, ctl, din}),
        .q     ({wr_n_s, mode_s, sel_s, ctl_s, din_s})
    );

    chrbuf_strobe #(.NUM_SEL(NUM_SEL)) u_strb (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_n_s  (wr_n_s),
        .sel_s   (sel_s),
        .act     (strb_act),
        .start_p (start_p),
        .end_p   (end_p)
    );

    // Capture mode, location and acceptance at strobe start; close the write at strobe end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            addr_q <= '0;
            busy_q <= 1'b0;
            oe_q   <= 1'b0;
        end else if (start_p) begin
            mode_q <= mode_s;
            if (mode_s) begin
                busy_q <= ctl_s[0] & ~seq_full;
            end else begin
                addr_q <= ctl_s;
                busy_q <= 1'b1;
                oe_q   <= 1'b0;
            end
        end else if (end_p) begin
            busy_q <= 1'b0;
            if (mode_q) oe_q <= 1'b1;
        end
    end

    assign clr     = mode_q & ~ctl_s[1];
    assign mem_we  = end_p & busy_q;
    assign seq_inc = mem_we & mode_q;
    assign wr_loc  = mode_q ? seq_loc : addr_q;

    chrbuf_seq_ctr #(.DEPTH(DEPTH)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc_i  (seq_inc),
        .clr_i  (clr),
        .loc_o  (seq_loc),
        .full_o (seq_full)
    );

    chrbuf_mem #(.DEPTH(DEPTH), .W(CODE_W)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we_i  (mem_we),
        .wa_i  (wr_loc),
        .wd_i  (din_s),
        .clr_i (clr),
        .ra_i  (rd_addr),
        .rd_o  (rd_data)
    );

    assign full_oe = oe_q;
    assign full_o  = oe_q & seq_full & ~standby;
    assign wr_busy = busy_q;

    // R9
    busy_in_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_busy |-> strb_act);
    // R5
    seq_write_not_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_inc |-> !seq_full);
    // R8
    oe_seq_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full_oe |-> mode_q);
endmodule

// File: tb/chrbuf_wr_ctrl_test.sv
// Bench: directed corners plus seeded random traffic against a reference model kept in the bench.
module chrbuf_wr_ctrl_test;
    localparam int NS = 2;
    localparam logic [5:0] BLANK = 6'b100000;

    logic clk = 1'b0, rst_n = 1'b0, wr_n = 1'b1, mode = 1'b0, standby = 1'b0;
    logic [NS-1:0] sel = '0;
    logic [2:0] ctl = 3'b010, rd_addr = '0;
    logic [5:0] din = '0, rd_data;
    logic full_o, full_oe, wr_busy;

    int checks = 0, fails = 0;
    logic [5:0] m_mem [8];
    int m_cnt = 0;
    logic m_mode = 1'b0, m_oe = 1'b0;

    always #10 clk = ~clk;

    chrbuf_wr_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .sel(sel), .mode(mode), .ctl(ctl),
        .din(din), .standby(standby), .rd_addr(rd_addr), .rd_data(rd_data),
        .full_o(full_o), .full_oe(full_oe), .wr_busy(wr_busy)
    );

    initial begin
        #(20 * 150000);
        fails++; checks++;
        $display("FAIL watchdog: run did not finish (act timeout, exp completion)");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    function automatic logic exp_full();
        return m_oe && (m_cnt == 8) && !standby;
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_mem(input string req);
        for (int a = 0; a < 8; a++) begin
            rd_addr = 3'(a);
            #1;
            chk(rd_data === m_mem[a], req, rd_data, m_mem[a]);
        end
    endtask

    task automatic chk_full(input string req);
        #1;
        chk(full_o === exp_full(), req, full_o, exp_full());
        chk(full_oe === m_oe, req, full_oe, m_oe);
    endtask

    // One bus write: ctl a0 at start, a1 during the strobe, data held through the end.
    task automatic do_write(input logic md, input logic [2:0] a0, input logic [2:0] a1,
                            input logic [5:0] d, input logic [NS-1:0] s);
        logic acc, full_ok;
        if (md) begin a0[1] = 1'b1; a1[1] = 1'b1; end
        if (!md && m_mode) a0[1] = 1'b1;
        sel = s; mode = md; ctl = a0; din = ~d;
        wait_n(4);
        wr_n = 1'b0;
        wait_n(6);
        ctl = a1; din = d;
        full_ok = (m_cnt < 8);
        acc = md ? (a0[0] && full_ok) : 1'b1;
        if (&s) begin
            #1;
            // R9 busy during strobe; R8 oe drops at random start, unchanged otherwise
            chk(wr_busy === acc, "R9", wr_busy, acc);
            chk(full_oe === (md ? m_oe : 1'b0), "R8", full_oe, md ? m_oe : 1'b0);
        end
        wait_n(4);
        wr_n = 1'b1;
        wait_n(6);
        if (&s) begin
            m_mode = md;
            if (!md) m_oe = 1'b0;
            if (acc) begin
                m_mem[md ? m_cnt[2:0] : a0] = d;
                if (md) m_cnt++;
            end
            if (md) m_oe = 1'b1;
            #1;
            chk(wr_busy === 1'b0, "R9", wr_busy, 0);
        end
        ctl = 3'b010; sel = '0;
        wait_n(2);
    endtask

    task automatic clr_pulse();
        ctl = 3'b000;
        wait_n(6);
        ctl = 3'b010;
        wait_n(5);
        if (m_mode) begin
            for (int a = 0; a < 8; a++) m_mem[a] = BLANK;
            m_cnt = 0;
        end
    endtask

    initial begin
        void'($urandom(32'd4711));
        for (int a = 0; a < 8; a++) m_mem[a] = BLANK;
        wait_n(4);
        rst_n = 1'b1;
        wait_n(4);
        // R11 reset state
        chk_mem("R11");
        #1;
        chk(full_o === 1'b0 && full_oe === 1'b0 && wr_busy === 1'b0, "R11",
            {full_o, full_oe, wr_busy}, 0);

        // R3 R4: location from start, address change mid-strobe ignored
        do_write(1'b0, 3'd5, 3'd2, 6'h11, '1);
        chk_mem("R3");
        do_write(1'b0, 3'd0, 3'd7, 6'h2a, '1);
        chk_mem("R4");

        // R1: partial selects, no write
        do_write(1'b0, 3'd3, 3'd3, 6'h3f, 2'b01);
        do_write(1'b0, 3'd4, 3'd4, 6'h3e, 2'b10);
        chk_mem("R1");

        // R7: clear ignored in random mode
        clr_pulse();
        chk_mem("R7");

        // R2 R8: switch to sequential, enable captured at start (flipped mid-strobe)
        clr_pulse();
        do_write(1'b1, 3'b011, 3'b010, 6'h01, '1);
        chk_mem("R2");
        chk_full("R8");

        // R5: enable low at start, high mid-strobe -> no write
        do_write(1'b1, 3'b010, 3'b011, 6'h3c, '1);
        chk_mem("R5");

        // R6: fill to eight entries
        for (int k = 0; k < 7; k++) do_write(1'b1, 3'b011, 3'b011, 6'(8'h20 + k), '1);
        chk_mem("R6");
        chk_full("R6");
        chk(full_o === 1'b1, "R6", full_o, 1);

        // R5: write while full is ignored
        do_write(1'b1, 3'b011, 3'b011, 6'h15, '1);
        chk_mem("R5");

        // R10: standby forces full low, memory intact
        standby = 1'b1;
        wait_n(3);
        chk_full("R10");
        chk(full_o === 1'b0, "R10", full_o, 0);
        chk_mem("R10");
        standby = 1'b0;
        wait_n(2);
        chk_full("R10");

        // R7: clear from full state
        clr_pulse();
        chk_mem("R7");
        chk_full("R7");

        // R8: back to random, oe drops at start
        do_write(1'b0, 3'd6, 3'd1, 6'h0f, '1);
        chk_full("R8");
        chk_mem("R3");

        // Random traffic
        for (int it = 0; it < 60; it++) begin
            int op;
            op = int'($urandom % 8);
            if (op == 0) begin
                clr_pulse();
            end else begin
                do_write(1'($urandom % 2), 3'($urandom), 3'($urandom), 6'($urandom),
                         (($urandom % 8) == 0) ? NS'(1) : '1);
            end
            chk_full("R6");
            rd_addr = 3'($urandom);
            #1;
            chk(rd_data === m_mem[rd_addr], "R4", rd_data, m_mem[rd_addr]);
        end
        chk_mem("R4");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule